// File: doc/BRIEF.md
# Debounced Pin Input Conditioner with Interrupts

This block conditions the inputs of a bank of general-purpose pins before software or other logic sees them. Every pin passes through a two-stage synchronizer and an optional inversion. It then goes through a digital debounce filter, which changes its output only after a programmed run of identical samples. Samples are not taken every clock. Each pin picks one bit of a shared free-running counter, and the pin samples once on every 0-to-1 transition of that bit. A higher bit gives a slower sample rate and a longer debounce window.

The lower group of pins can also raise interrupts. Per pin, an enable bit gates the source, and a type bit chooses between two kinds of interrupt:
- Level: the source follows the filtered value.
- Rising edge: a sticky latch is set on each 0-to-1 filtered transition and is cleared by a write-one-to-clear mask.

All enabled sources are combined into one interrupt line. The filtered values of all pins are presented on a read port.

Top module: `gpio_in_filter`

## Requirements
- R1: After reset, every filtered value, every interrupt source and the combined interrupt line are 0.
- R2: The value sampled for pin i is its synchronized pad input (two flops) XORed with `cfg_invert[i]`.
- R3: Pin i takes a sample only in a cycle where bit `cfg_rate_sel[4i+3:4i]` of a 16-bit counter has just gone from 0 to 1. The counter is cleared by reset and increments every clock. Between samples the filtered value holds.
- R4: Let the field `cfg_run_len[4i+3:4i]` hold k. The filtered value takes a new level after k+1 consecutive samples that differ from it. With k = 0 a single differing sample is enough. A sample equal to the current value restarts the run. Pins 16 to 23 are filtered in the same way.
- R5: With `cfg_irq_edge[i]` = 0 (level type), `irq_src[i]` is 1 while pin i's filtered value is 1 and `cfg_irq_en[i]` is 1.
- R6: With `cfg_irq_edge[i]` = 1 (rising-edge type), a 0-to-1 filtered transition sets a latch that stays set after the pin returns to 0. `irq_src[i]` shows the latch only while `cfg_irq_en[i]` is 1.
- R7: A cycle with `clr_we` = 1 clears the latch of each pin whose `clr_mask` bit is 1 and leaves the others untouched. A rising edge in the same cycle as its clear leaves the latch set.
- R8: `irq_out` is 1 exactly when at least one bit of `irq_src` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pad_in | input | 24 | Raw pin values |
| cfg_invert | input | 24 | Per-pin input inversion |
| cfg_rate_sel | input | 96 | Per-pin 4-bit counter bit select |
| cfg_run_len | input | 96 | Per-pin 4-bit debounce run length |
| cfg_irq_en | input | 16 | Per-pin interrupt enable |
| cfg_irq_edge | input | 16 | Per-pin interrupt type, 1 = rising edge |
| clr_we | input | 1 | Clear strobe for the edge latches |
| clr_mask | input | 16 | Latches to clear when clr_we is 1 |
| pin_state | output | 24 | Filtered pin values |
| irq_src | output | 16 | Per-pin interrupt sources after enable |
| irq_out | output | 1 | OR of all interrupt sources |

## Verification
The filter is driven with clean steps at the fastest sample rate, which shows that a zero run length reacts on the first differing sample. Short pulses under a long run length must be rejected, which tells a correct run counter apart from one that never restarts. A step on a pin set to a slow counter bit is checked both before and after two sample periods, which separates correct rate selection from sampling every clock. The interrupt paths are tried in both types, with enable toggled, with a clear whose mask misses the pin, and with a clear held while an edge arrives, which shows the edge taking priority as a one-cycle pulse.

// File: rtl/gpf_pkg.sv
package gpf_pkg;
    parameter int RUN_W = 4;

    typedef struct packed {
        logic             meta;
        logic             sync;
        logic             level;
        logic [RUN_W-1:0] run;
    } filt_st_t;
endpackage

// File: rtl/gpf_tick.sv
module gpf_tick #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] tick
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q + CNT_W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    // bit b has just risen when it is set and every lower bit is clear
    for (genvar b = 0; b < CNT_W; b++) begin : g_tick
        localparam logic [CNT_W-1:0] LOW = (CNT_W'(1) << b) - CNT_W'(1);
        assign tick[b] = cnt_q[b] && ((cnt_q & LOW) == '0);
    end
endmodule

// File: rtl/gpf_pin_filter.sv
module gpf_pin_filter
    import gpf_pkg::*;
#(
    parameter int TICK_W = 16,
    localparam int SEL_W = $clog2(TICK_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pad,
    input  logic              invert,
    input  logic [SEL_W-1:0]  rate_sel,
    input  logic [RUN_W-1:0]  run_len,
    input  logic [TICK_W-1:0] tick,
    output logic              strobe,
    output logic              level_q,
    output logic              level_d
);
    filt_st_t st_d, st_q;
    logic     smp;

    always_comb begin
        strobe  = tick[rate_sel];
        smp     = st_q.sync ^ invert;
        st_d    = st_q;
        st_d.meta = pad;
        st_d.sync = st_q.meta;
        if (strobe) begin
            if (smp == st_q.level) begin
                st_d.run = '0;
            end else if (st_q.run >= run_len) begin
                st_d.level = smp;
                st_d.run   = '0;
            end else begin
                st_d.run = st_q.run + RUN_W'(1);
            end
        end
        level_d = st_d.level;
        level_q = st_q.level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/gpf_irq.sv
module gpf_irq #(
    parameter int N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl_q,
    input  logic [N-1:0] lvl_d,
    input  logic [N-1:0] en,
    input  logic [N-1:0] edge_mode,
    input  logic         clr_we,
    input  logic [N-1:0] clr_mask,
    output logic [N-1:0] latch,
    output logic [N-1:0] src,
    output logic         any
);
    logic [N-1:0] latch_d, latch_q, wipe, rise;

    always_comb begin
        wipe    = clr_we ? clr_mask : '0;
        rise    = lvl_d & ~lvl_q;
        // a fresh edge wins over a clear in the same cycle
        latch_d = (latch_q & ~wipe) | rise;
        src     = en & ((edge_mode & latch_q) | (~edge_mode & lvl_q));
        any     = |src;
        latch   = latch_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) latch_q <= '0;
        else        latch_q <= latch_d;
    end
endmodule

// File: rtl/gpio_in_filter.sv
module gpio_in_filter
    import gpf_pkg::*;
#(
    parameter int NUM_PINS = 24,
    parameter int NUM_IRQ  = 16,
    parameter int CNT_W    = 16,
    localparam int SEL_W   = $clog2(CNT_W)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_PINS-1:0]       pad_in,
    input  logic [NUM_PINS-1:0]       cfg_invert,
    input  logic [NUM_PINS*SEL_W-1:0] cfg_rate_sel,
    input  logic [NUM_PINS*RUN_W-1:0] cfg_run_len,
    input  logic [NUM_IRQ-1:0]        cfg_irq_en,
    input  logic [NUM_IRQ-1:0]        cfg_irq_edge,
    input  logic                      clr_we,
    input  logic [NUM_IRQ-1:0]        clr_mask,
    output logic [NUM_PINS-1:0]       pin_state,
    output logic [NUM_IRQ-1:0]        irq_src,
    output logic                      irq_out
);
    logic [CNT_W-1:0]    tick;
    logic [NUM_PINS-1:0] pin_strobe;
    logic [NUM_PINS-1:0] lvl_next;
    logic [NUM_IRQ-1:0]  irq_latch;

    gpf_tick #(.CNT_W(CNT_W)) u_tick (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (tick)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        gpf_pin_filter #(.TICK_W(CNT_W)) u_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .pad     (pad_in[i]),
            .invert  (cfg_invert[i]),
            .rate_sel(cfg_rate_sel[i*SEL_W +: SEL_W]),
            .run_len (cfg_run_len[i*RUN_W +: RUN_W]),
            .tick    (tick),
            .strobe  (pin_strobe[i]),
            .level_q (pin_state[i]),
            .level_d (lvl_next[i])
        );
    end

    gpf_irq #(.N(NUM_IRQ)) u_irq (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl_q    (pin_state[NUM_IRQ-1:0]),
        .lvl_d    (lvl_next[NUM_IRQ-1:0]),
        .en       (cfg_irq_en),
        .edge_mode(cfg_irq_edge),
        .clr_we   (clr_we),
        .clr_mask (clr_mask),
        .latch    (irq_latch),
        .src      (irq_src),
        .any      (irq_out)
    );
endmodule

// File: rtl/gpf_checker.sv
module gpf_checker #(
    parameter int NP = 24,
    parameter int NI = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic [NP-1:0] pin_state,
    input logic [NP-1:0] pin_strobe,
    input logic [NI-1:0] irq_latch,
    input logic          clr_we,
    input logic [NI-1:0] clr_mask
);
    p_hold_between_ticks_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_state ^ $past(pin_state)) & ~$past(pin_strobe)) == '0);

    p_edge_captured_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_state[NI-1:0] & ~$past(pin_state[NI-1:0]) & ~irq_latch) == '0);

    p_sticky_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(irq_latch) & ~irq_latch & ~($past(clr_we) ? $past(clr_mask) : '0)) == '0);

    p_clear_effective_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we |=> (irq_latch & $past(clr_mask)
                    & ~(pin_state[NI-1:0] & ~$past(pin_state[NI-1:0]))) == '0);
endmodule

bind gpio_in_filter gpf_checker #(.NP(NUM_PINS), .NI(NUM_IRQ)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_state (pin_state),
    .pin_strobe(pin_strobe),
    .irq_latch (irq_latch),
    .clr_we    (clr_we),
    .clr_mask  (clr_mask)
);

// File: tb/gpio_in_filter_test.sv
module gpio_in_filter_test;
    localparam int NP = 24;
    localparam int NI = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NP-1:0]   pad_in = '0;
    logic [NP-1:0]   cfg_invert = '0;
    logic [NP*4-1:0] cfg_rate_sel = '0;
    logic [NP*4-1:0] cfg_run_len = '0;
    logic [NI-1:0]   cfg_irq_en = '0;
    logic [NI-1:0]   cfg_irq_edge = '0;
    logic            clr_we = 1'b0;
    logic [NI-1:0]   clr_mask = '0;
    logic [NP-1:0]   pin_state;
    logic [NI-1:0]   irq_src;
    logic            irq_out;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int pulse_seen = 0;
    bit count_pulse = 0;

    always #10 clk = ~clk;

    gpio_in_filter uut (
        .clk(clk), .rst_n(rst_n), .pad_in(pad_in), .cfg_invert(cfg_invert),
        .cfg_rate_sel(cfg_rate_sel), .cfg_run_len(cfg_run_len),
        .cfg_irq_en(cfg_irq_en), .cfg_irq_edge(cfg_irq_edge),
        .clr_we(clr_we), .clr_mask(clr_mask),
        .pin_state(pin_state), .irq_src(irq_src), .irq_out(irq_out)
    );

    // behavioural reference
    bit m_s1[NP], m_s2[NP], m_lvl[NP];
    int m_run[NP];
    bit m_latch[NI];
    int m_cnt = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NP; i++) begin
                m_s1[i] = 0; m_s2[i] = 0; m_lvl[i] = 0; m_run[i] = 0;
            end
            for (int i = 0; i < NI; i++) m_latch[i] = 0;
            m_cnt = 0;
        end else begin
            for (int i = 0; i < NP; i++) begin
                int sel, len, prev;
                bit tk, smp, nl;
                sel  = int'(cfg_rate_sel[i*4 +: 4]);
                len  = int'(cfg_run_len[i*4 +: 4]);
                prev = (m_cnt + 65535) % 65536;
                tk   = (((m_cnt >> sel) & 1) == 1) && (((prev >> sel) & 1) == 0);
                smp  = m_s2[i] ^ cfg_invert[i];
                nl   = m_lvl[i];
                if (tk) begin
                    if (smp == m_lvl[i]) m_run[i] = 0;
                    else if (m_run[i] >= len) begin nl = smp; m_run[i] = 0; end
                    else m_run[i] = m_run[i] + 1;
                end
                if (i < NI)
                    m_latch[i] = (m_latch[i] && !(clr_we && clr_mask[i])) || (nl && !m_lvl[i]);
                m_lvl[i] = nl;
                m_s2[i]  = m_s1[i];
                m_s1[i]  = pad_in[i];
            end
            m_cnt = (m_cnt + 1) % 65536;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            logic [NP-1:0] e_pin;
            logic [NI-1:0] e_src;
            for (int i = 0; i < NP; i++) e_pin[i] = m_lvl[i];
            for (int i = 0; i < NI; i++)
                e_src[i] = cfg_irq_en[i] && (cfg_irq_edge[i] ? m_latch[i] : m_lvl[i]);
            chk("R4 trace pin_state", 32'(pin_state), 32'(e_pin));
            chk("R6 trace irq_src", 32'(irq_src), 32'(e_src));
            chk("R8 trace irq_out", 32'(irq_out), 32'(|e_src));
            if (count_pulse && irq_src[9]) pulse_seen++;
        end
    end

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            checks++; fails++;
            $display("FAIL watchdog actual=%0d expected=finish", cyc);
            summary();
            $finish;
        end
    end

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        wait_cyc(4);
        rst_n = 1'b1;
        wait_cyc(1);
        chk("R1 pin_state", 32'(pin_state), 0);
        chk("R1 irq_src", 32'(irq_src), 0);
        chk("R1 irq_out", 32'(irq_out), 0);

        // R2: inversion on an idle pad
        cfg_invert[5] = 1'b1;
        wait_cyc(10);
        chk("R2 inverted pin 5", 32'(pin_state[5]), 1);
        cfg_invert[5] = 1'b0;
        wait_cyc(10);
        chk("R2 inversion removed", 32'(pin_state[5]), 0);

        // R4: zero run length reacts fast
        pad_in[3] = 1'b1;
        wait_cyc(8);
        chk("R4 zero run length", 32'(pin_state[3]), 1);

        // R4: short pulses rejected with run length 3
        cfg_run_len[7*4 +: 4] = 4'd3;
        pad_in[7] = 1'b1;
        wait_cyc(4);
        pad_in[7] = 1'b0;
        wait_cyc(30);
        chk("R4 glitch rejected", 32'(pin_state[7]), 0);
        pad_in[7] = 1'b1;
        wait_cyc(20);
        chk("R4 long level accepted", 32'(pin_state[7]), 1);

        // R3: slow sample rate on an upper pin
        cfg_rate_sel[20*4 +: 4] = 4'd3;
        cfg_run_len[20*4 +: 4]  = 4'd1;
        pad_in[20] = 1'b1;
        wait_cyc(12);
        chk("R3 slow rate not yet", 32'(pin_state[20]), 0);
        wait_cyc(60);
        chk("R3 slow rate reached", 32'(pin_state[20]), 1);

        // R5 level interrupt, R8 combine
        cfg_irq_en[3] = 1'b1;
        wait_cyc(2);
        chk("R5 level source", 32'(irq_src[3]), 1);
        chk("R8 combined high", 32'(irq_out), 1);
        pad_in[3] = 1'b0;
        wait_cyc(8);
        chk("R5 level source low", 32'(irq_src[3]), 0);
        chk("R8 combined low", 32'(irq_out), 0);

        // R6 edge interrupt
        cfg_irq_en[9] = 1'b1;
        cfg_irq_edge[9] = 1'b1;
        pad_in[9] = 1'b1;
        wait_cyc(8);
        chk("R6 edge latched", 32'(irq_src[9]), 1);
        pad_in[9] = 1'b0;
        wait_cyc(8);
        chk("R6 edge sticky", 32'(irq_src[9]), 1);
        cfg_irq_en[9] = 1'b0;
        wait_cyc(1);
        chk("R6 masked by enable", 32'(irq_src[9]), 0);
        chk("R8 masked combined", 32'(irq_out), 0);
        cfg_irq_en[9] = 1'b1;
        wait_cyc(1);
        chk("R6 re-enabled", 32'(irq_src[9]), 1);

        // R7 clear with other mask bit
        clr_mask = 16'h0004; clr_we = 1'b1;
        wait_cyc(1);
        clr_we = 1'b0; clr_mask = '0;
        wait_cyc(2);
        chk("R7 other bit no effect", 32'(irq_src[9]), 1);
        clr_mask = 16'h0200; clr_we = 1'b1;
        wait_cyc(1);
        clr_we = 1'b0; clr_mask = '0;
        wait_cyc(2);
        chk("R7 cleared", 32'(irq_src[9]), 0);

        // R7 edge during a held clear leaves a one-cycle pulse
        clr_mask = 16'h0200; clr_we = 1'b1;
        pulse_seen = 0; count_pulse = 1;
        pad_in[9] = 1'b1;
        wait_cyc(12);
        count_pulse = 0;
        chk("R7 edge beats clear", 32'(pulse_seen), 1);
        clr_we = 1'b0; clr_mask = '0;
        wait_cyc(4);
        chk("R7 after held clear", 32'(irq_src[9]), 0);

        summary();
        $finish;
    end
endmodule